// File: doc/BRIEF.md
# Register Shadow Condition Flags with Alignment Predicates

This block keeps a small record of condition bits for every entry of a register file. Each time a register is written, the block derives the bits from the written value and stores them. The bits are a zero indicator, a sign indicator, an odd indicator and up to two alignment indicators. A branch unit can then ask whether a condition holds for a given register, and the answer comes from the stored bits alone. No ALU operation and no scratch register are needed.

A second query port serves the memory pipeline. It takes the index of a pointer register and an access size, and it raises a trap request when the pointer is not aligned for that size. The check runs before the access is issued, so an unaligned access never reaches memory. The alignment indicators are ORs over a growing number of low bits of the value: one bit, then two, then three. Which of them exist depends on the configured datapath width of 16, 32 or 64 bits.

Both query ports are combinational. When a query names the register that is being written in the same cycle, it sees the flags of the incoming value.

Top module: `shadow_flag_file`

## Requirements
- R1: After reset, every register's flags read as those of a zero value: the zero flag is set and the sign, odd and both alignment flags are clear.
- R2: The zero flag is set exactly when the last value written to the register is all zeros across the full datapath width.
- R3: The sign flag equals the most significant bit (bit DATA_W-1) of the last written value.
- R4: The odd flag equals bit 0 of the last written value.
- R5: The two-bit alignment flag is the OR of bits 1 and 0 when DATA_W is 32 or more. With DATA_W of 16 it always reads false.
- R6: The three-bit alignment flag is the OR of bits 2 down to 0 when DATA_W is 64. Otherwise it always reads false.
- R7: cond_code[3:1] selects the flag to test: 0 zero, 1 sign, 2 odd, 3 two-bit alignment, 4 three-bit alignment, and 5 to 7 always false. cond_code[0]=1 inverts the result.
- R8: A condition query or alignment check that names the register being written in the same cycle uses the flags of wr_data, not the stored ones.
- R9: chk_size encodes 0 byte, 1 16-bit, 2 32-bit, 3 64-bit. With chk_valid high, trap_req is raised for 16-bit when the odd flag is set, for 32-bit when the two-bit alignment flag is set, and for 64-bit when the three-bit alignment flag is set.
- R10: trap_req stays low for byte accesses and whenever chk_valid is low.
- R11: A write to one register leaves the flags of every other register unchanged.
- R12: When wr_en is low, the values on wr_idx and wr_data change no stored flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | $clog2(NUM_REGS) | Register being written |
| wr_data | input | DATA_W | Value being written |
| cond_idx | input | $clog2(NUM_REGS) | Register tested by the condition port |
| cond_code | input | 4 | Flag select in [3:1], invert in [0] |
| cond_taken | output | 1 | Condition result (taken) |
| chk_valid | input | 1 | Alignment check request |
| chk_idx | input | $clog2(NUM_REGS) | Pointer register to check |
| chk_size | input | 2 | Access size code |
| trap_req | output | 1 | Unaligned access trap request |

## Verification
A register write and a query of the same register can occur in the same cycle, and the bypass must then hand the query the new value's flags. The bench provokes this in every write cycle. While the write is held on the port, it points both query ports at the target register and steps through all sixteen condition codes and all four access sizes. Each answer is compared with flags computed arithmetically from wr_data. In the cycle that follows, the same sweep is repeated against the stored copy, so bypass and storage are judged separately.

// File: rtl/sff_pkg.sv
`timescale 1ns/1ps
package sff_pkg;

    // Shadow condition bits kept per register
    typedef struct packed {
        logic z;    // value is zero
        logic s;    // most significant bit
        logic p1;   // bit 0 (odd)
        logic p2;   // OR of two low bits
        logic p3;   // OR of three low bits
    } cond_flags_t;

    localparam cond_flags_t FLAGS_AT_RESET = '{z: 1'b1, s: 1'b0, p1: 1'b0, p2: 1'b0, p3: 1'b0};

    typedef enum logic [2:0] {
        SEL_ZERO   = 3'd0,
        SEL_SIGN   = 3'd1,
        SEL_ODD    = 3'd2,
        SEL_ALIGN2 = 3'd3,
        SEL_ALIGN3 = 3'd4
    } cond_sel_e;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_DWORD = 2'd3
    } acc_size_e;

    // Flag chosen by a selector; undefined selectors give false
    function automatic logic pick_flag(cond_flags_t f, logic [2:0] sel);
        logic r;
        case (sel)
            SEL_ZERO:   r = f.z;
            SEL_SIGN:   r = f.s;
            SEL_ODD:    r = f.p1;
            SEL_ALIGN2: r = f.p2;
            SEL_ALIGN3: r = f.p3;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    // Misalignment for an access size
    function automatic logic misaligned(cond_flags_t f, acc_size_e sz);
        logic r;
        case (sz)
            ACC_HALF:  r = f.p1;
            ACC_WORD:  r = f.p2;
            ACC_DWORD: r = f.p3;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sff_flag_gen.sv
`timescale 1ns/1ps
module sff_flag_gen
    import sff_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] data,
    output cond_flags_t       flags
);
    logic align2;
    logic align3;

    // Alignment bits exist only where the width supports the access size
    generate
        if (DATA_W >= 32) begin : g_align2
            assign align2 = |data[1:0];
        end else begin : g_no_align2
            assign align2 = 1'b0;
        end
        if (DATA_W >= 64) begin : g_align3
            assign align3 = |data[2:0];
        end else begin : g_no_align3
            assign align3 = 1'b0;
        end
    endgenerate

    always_comb begin
        flags.z  = (data == '0);
        flags.s  = data[DATA_W-1];
        flags.p1 = data[0];
        flags.p2 = align2;
        flags.p3 = align3;
    end
endmodule

// File: rtl/sff_flag_bank.sv
`timescale 1ns/1ps
module sff_flag_bank
    import sff_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  cond_flags_t       wr_flags,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output cond_flags_t       rd_a_flags,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output cond_flags_t       rd_b_flags
);
    cond_flags_t bank [NUM_REGS];

    // One flag entry per register, each with its own write decode
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank[i] <= FLAGS_AT_RESET;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    bank[i] <= wr_flags;
                end
            end
        end
    endgenerate

    // Same-cycle bypass on both read ports
    always_comb begin
        rd_a_flags = (wr_en && (wr_idx == rd_a_idx)) ? wr_flags : bank[rd_a_idx];
        rd_b_flags = (wr_en && (wr_idx == rd_b_idx)) ? wr_flags : bank[rd_b_idx];
    end
endmodule

// File: rtl/sff_cond_eval.sv
`timescale 1ns/1ps
module sff_cond_eval
    import sff_pkg::*;
(
    input  cond_flags_t flags,
    input  logic [3:0]  code,
    output logic        taken
);
    logic raw;

    always_comb begin
        raw   = pick_flag(flags, code[3:1]);
        taken = raw ^ code[0];
    end
endmodule

// File: rtl/sff_align_check.sv
`timescale 1ns/1ps
module sff_align_check
    import sff_pkg::*;
(
    input  cond_flags_t flags,
    input  logic        valid,
    input  logic [1:0]  size,
    output logic        trap
);
    always_comb begin
        trap = valid && misaligned(flags, acc_size_e'(size));
    end
endmodule

// File: rtl/shadow_flag_file.sv
`timescale 1ns/1ps
module shadow_flag_file
    import sff_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  cond_idx,
    input  logic [3:0]        cond_code,
    output logic              cond_taken,
    input  logic              chk_valid,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic [1:0]        chk_size,
    output logic              trap_req
);
    cond_flags_t new_flags;
    cond_flags_t cond_flags;
    cond_flags_t chk_flags;

    sff_flag_gen #(.DATA_W(DATA_W)) u_gen (
        .data  (wr_data),
        .flags (new_flags)
    );

    sff_flag_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_flags   (new_flags),
        .rd_a_idx   (cond_idx),
        .rd_a_flags (cond_flags),
        .rd_b_idx   (chk_idx),
        .rd_b_flags (chk_flags)
    );

    sff_cond_eval u_cond (
        .flags (cond_flags),
        .code  (cond_code),
        .taken (cond_taken)
    );

    sff_align_check u_align (
        .flags (chk_flags),
        .valid (chk_valid),
        .size  (chk_size),
        .trap  (trap_req)
    );
endmodule

// File: rtl/sff_checker.sv
`timescale 1ns/1ps
module sff_checker #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [IDX_W-1:0]  cond_idx,
    input logic [3:0]        cond_code,
    input logic              cond_taken,
    input logic              chk_valid,
    input logic [IDX_W-1:0]  chk_idx,
    input logic [1:0]        chk_size,
    input logic              trap_req
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en && cond_code == 4'b0000) |-> cond_taken);

    a_r2_zero_bypass: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == cond_idx && cond_code == 4'b0000) |-> (cond_taken == (wr_data == '0)));

    a_r3_sign_bypass: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == cond_idx && cond_code == 4'b0010) |-> (cond_taken == wr_data[DATA_W-1]));

    a_r4_stored_odd: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && !wr_en && cond_idx == $past(wr_idx) && cond_code == 4'b0100)
        |-> (cond_taken == $past(wr_data[0])));

    a_r7_reserved_sel: assert property (@(posedge clk) disable iff (rst)
        (cond_code[3:1] > 3'd4) |-> (cond_taken == cond_code[0]));

    a_r9_half_trap_bypass: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_size == 2'd1 && wr_en && wr_idx == chk_idx) |-> (trap_req == wr_data[0]));

    a_r10_byte_no_trap: assert property (@(posedge clk) disable iff (rst)
        (chk_size == 2'd0) |-> !trap_req);

    a_r10_idle_no_trap: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |-> !trap_req);
endmodule

bind shadow_flag_file sff_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sff_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cond_idx   (cond_idx),
    .cond_code  (cond_code),
    .cond_taken (cond_taken),
    .chk_valid  (chk_valid),
    .chk_idx    (chk_idx),
    .chk_size   (chk_size),
    .trap_req   (trap_req)
);

// File: tb/shadow_flag_file_tb_top.sv
`timescale 1ns/1ps
module shadow_flag_file_tb_top;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  cond_idx = '0;
    logic [3:0]  cond_code = '0;
    logic        chk_valid = 1'b0;
    logic [2:0]  chk_idx = '0;
    logic [1:0]  chk_size = '0;
    logic        taken64, trap64, taken16, trap16;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] model [NREG];

    always #2.5 clk = ~clk;

    shadow_flag_file #(.DATA_W(64), .NUM_REGS(NREG)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cond_idx(cond_idx), .cond_code(cond_code), .cond_taken(taken64),
        .chk_valid(chk_valid), .chk_idx(chk_idx), .chk_size(chk_size), .trap_req(trap64)
    );

    shadow_flag_file #(.DATA_W(16), .NUM_REGS(NREG)) dut16_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data[15:0]),
        .cond_idx(cond_idx), .cond_code(cond_code), .cond_taken(taken16),
        .chk_valid(chk_valid), .chk_idx(chk_idx), .chk_size(chk_size), .trap_req(trap16)
    );

    function automatic logic exp_cond(logic [63:0] v, int w, logic [3:0] code);
        logic [63:0] m;
        logic r;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        case (code[3:1])
            3'd0:    r = ((v & m) == 64'd0);
            3'd1:    r = v[w-1];
            3'd2:    r = v[0];
            3'd3:    r = (w >= 32) && (v[1:0] != 2'd0);
            3'd4:    r = (w == 64) && (v[2:0] != 3'd0);
            default: r = 1'b0;
        endcase
        return r ^ code[0];
    endfunction

    function automatic logic exp_trap(logic [63:0] v, int w, logic valid, logic [1:0] sz);
        logic r;
        case (sz)
            2'd1:    r = v[0];
            2'd2:    r = (w >= 32) && (v[1:0] != 2'd0);
            2'd3:    r = (w == 64) && (v[2:0] != 3'd0);
            default: r = 1'b0;
        endcase
        return valid && r;
    endfunction

    function automatic string sel_tag(logic [2:0] s);
        case (s)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(logic act, logic exp, string tag, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Queries one register on both ports across every code and size.
    // Occupies 2.1 ns of the low clock phase.
    task automatic sweep_reg(int idx, logic [63:0] v, string ctx);
        cond_idx = 3'(idx);
        chk_idx  = 3'(idx);
        for (int c = 0; c < 16; c++) begin
            cond_code = 4'(c);
            #0.1;
            check(taken64, exp_cond(v, 64, 4'(c)), {ctx, "/", sel_tag(3'(c >> 1))},
                  $sformatf("w64 reg%0d code%0d v=%h", idx, c, v));
            check(taken16, exp_cond(v, 16, 4'(c)), {ctx, "/", sel_tag(3'(c >> 1))},
                  $sformatf("w16 reg%0d code%0d v=%h", idx, c, v[15:0]));
        end
        chk_valid = 1'b0;
        chk_size  = 2'd3;
        #0.1;
        check(trap64, 1'b0, {ctx, "/R10"}, $sformatf("w64 idle check reg%0d", idx));
        check(trap16, 1'b0, {ctx, "/R10"}, $sformatf("w16 idle check reg%0d", idx));
        chk_valid = 1'b1;
        for (int s = 0; s < 4; s++) begin
            chk_size = 2'(s);
            #0.1;
            check(trap64, exp_trap(v, 64, 1'b1, 2'(s)), {ctx, (s == 0) ? "/R10" : "/R9"},
                  $sformatf("w64 size%0d reg%0d v=%h", s, idx, v));
            check(trap16, exp_trap(v, 16, 1'b1, 2'(s)), {ctx, (s == 0) ? "/R10" : "/R9"},
                  $sformatf("w16 size%0d reg%0d v=%h", s, idx, v[15:0]));
        end
        chk_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] hi_tab [4];
        hi_tab[0] = 64'h0;
        hi_tab[1] = 64'h8000_0000_0000_8000;
        hi_tab[2] = 64'h0001_0000_0001_0000;
        hi_tab[3] = 64'hFFFF_FFFF_FFFF_FFF0;
        for (int i = 0; i < NREG; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state of every register
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            sweep_reg(r, 64'd0, "R1");
        end

        for (int p = 0; p < 64; p++) begin
            automatic int r = p % NREG;
            automatic int nb = (r + 1) % NREG;
            automatic logic [63:0] v = hi_tab[p >> 4] | 64'(p & 15);
            // R8: write and query in the same cycle
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 3'(r); wr_data = v;
            sweep_reg(r, v, "R8");
            @(posedge clk);
            model[r] = v;
            // R12: write strobe low with other data on the bus
            @(negedge clk);
            wr_en = 1'b0; wr_idx = 3'(r); wr_data = ~v;
            sweep_reg(r, v, "R12");
            @(negedge clk);
            sweep_reg(r, model[r], "R12");
            // R11: neighbouring register untouched
            @(negedge clk);
            sweep_reg(nb, model[nb], "R11");
        end

        // R11: final scan of every register
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            sweep_reg(r, model[r], "R11");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule